// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block resolves one translation miss at a time by reading a two-level page table from physical memory. A miss arrives as a 20-bit virtual page number and a root pointer. The upper ten bits of the page number select an entry in the first-level table. If that entry is valid, it names the page that holds a second-level table. The lower ten bits then select the leaf entry in that table. Both tables sit in untranslated physical memory, and each read is one 32-bit word. The page offset never reaches the walker, because it takes no part in the lookup.

Reads go out over a request channel with a valid/ready handshake and come back on a response channel with a valid strobe. The walker accepts any response latency. A walk ends in one of two ways. In the first, a one-cycle completion pulse comes with the decoded leaf: the physical page number, three access-right bits and the remaining status bits. In the second, a one-cycle fault pulse reports the level at which a missing table or page was found. The block does no TLB storage, no page filling and no caching.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are all low.
- R2: A miss is taken only while `busy` is low. A `miss_valid` seen while a walk is running, or during the cycle of its `done`/`fault` pulse, starts no walk and issues no memory request.
- R3: The first read addresses `root_ptr + 4*miss_vpn[19:10]`, using the root pointer and page number captured when the miss is taken. While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` stay unchanged.
- R4: After a valid first-level response, the second read addresses `{L1entry[31:12], 12'h000} + 4*miss_vpn[9:0]`.
- R5: Bit 0 of an entry is its valid bit. A first-level entry with bit 0 clear gives a one-cycle `fault` with `fault_lvl`=0 in the cycle after the response, and no second read is made.
- R6: A second-level entry with bit 0 clear gives a one-cycle `fault` with `fault_lvl`=1 in the cycle after the response.
- R7: A valid leaf gives a one-cycle `done` in the cycle after the response, with `res_ppn`=entry[31:12], `res_perm`=entry[3:1] (bit 1 read, bit 2 write, bit 3 execute) and `res_attr`=entry[11:4]. `done` and `fault` are never both high.
- R8: `busy` goes high in the cycle after a miss is taken. It stays high through the `done`/`fault` cycle and is low in the cycle after.
- R9: A `mem_rsp_valid` that arrives while no read is outstanding is ignored.
- R10: The walker waits any number of cycles for `mem_req_ready` and for `mem_rsp_valid`. It does not request again while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | 20 | Virtual page number of the miss |
| root_ptr | input | 32 | Physical address of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word read |
| done | output | 1 | One-cycle pulse: leaf found |
| fault | output | 1 | One-cycle pulse: page fault |
| fault_lvl | output | 1 | Faulting level (0 first, 1 second) |
| res_ppn | output | 20 | Leaf physical page number |
| res_perm | output | 3 | Leaf access rights |
| res_attr | output | 8 | Leaf remaining status bits |

## Verification
Two things can land in the same cycle: a new miss request and the completion or fault pulse of the walk that is ending. The bench raises `miss_valid` exactly in the `done` cycle, and in a separate test in the `fault` cycle. It then checks that `busy` and `mem_req_valid` stay low in the two following cycles, so the request was dropped and not queued. A second overlap is a stray response that arrives while a request is still waiting for `mem_req_ready`. The bench checks that the held request address is unchanged and that the walk finishes with the expected leaf.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        PW_IDLE,
        PW_L1_REQ,
        PW_L1_WAIT,
        PW_L2_REQ,
        PW_L2_WAIT,
        PW_DONE,
        PW_FAULT
    } pw_state_e;
endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
    parameter int VPN_W    = 20,
    parameter int L2_IDX_W = 10,
    parameter int PA_W     = 32,
    parameter int OFF_W    = 12,
    parameter int ENTRY_SH = 2
) (
    input  logic [VPN_W-1:0]      vpn,
    input  logic [PA_W-1:0]       root,
    input  logic [PA_W-OFF_W-1:0] tbl_ppn,
    input  logic                  second,
    output logic [PA_W-1:0]       addr
);
    localparam int L1_IDX_W = VPN_W - L2_IDX_W;

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] offs;

    always_comb begin
        if (second) begin
            base = {tbl_ppn, {OFF_W{1'b0}}};
            offs = PA_W'(vpn[L2_IDX_W-1:0]) << ENTRY_SH;
        end else begin
            base = root;
            offs = PA_W'(vpn[VPN_W-1 -: L1_IDX_W]) << ENTRY_SH;
        end
        addr = base + offs;
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int PERM_W = 3
) (
    input  logic [PA_W-1:0]           entry,
    output logic                      valid,
    output logic [PA_W-OFF_W-1:0]     ppn,
    output logic [PERM_W-1:0]         perm,
    output logic [OFF_W-PERM_W-2:0]   attr
);
    assign valid = entry[0];
    assign perm  = entry[PERM_W:1];
    assign attr  = entry[OFF_W-1:PERM_W+1];
    assign ppn   = entry[PA_W-1:OFF_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    parameter int OFF_W    = 12,
    parameter int PERM_W   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              miss_valid,
    input  logic [L1_IDX_W+L2_IDX_W-1:0]      miss_vpn,
    input  logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] root_ptr,
    output logic                              busy,
    output logic                              mem_req_valid,
    input  logic                              mem_req_ready,
    output logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] mem_req_addr,
    input  logic                              mem_rsp_valid,
    input  logic [L1_IDX_W+L2_IDX_W+OFF_W-1:0] mem_rsp_data,
    output logic                              done,
    output logic                              fault,
    output logic                              fault_lvl,
    output logic [L1_IDX_W+L2_IDX_W-1:0]      res_ppn,
    output logic [PERM_W-1:0]                 res_perm,
    output logic [OFF_W-PERM_W-2:0]           res_attr
);
    localparam int VPN_W    = L1_IDX_W + L2_IDX_W;
    localparam int PA_W     = VPN_W + OFF_W;
    localparam int PPN_W    = PA_W - OFF_W;
    localparam int ATTR_W   = OFF_W - PERM_W - 1;
    localparam int ENTRY_SH = $clog2(PA_W / 8);

    typedef struct packed {
        pw_state_e         st;
        logic [VPN_W-1:0]  vpn;
        logic [PA_W-1:0]   root;
        logic [PPN_W-1:0]  tbl;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic [ATTR_W-1:0] attr;
        logic              flvl;
    } walk_s;

    walk_s walk_d, walk_q;

    logic              dec_valid;
    logic [PPN_W-1:0]  dec_ppn;
    logic [PERM_W-1:0] dec_perm;
    logic [ATTR_W-1:0] dec_attr;
    logic              use_l2;

    assign use_l2 = (walk_q.st == PW_L2_REQ);

    ptw_addr_calc #(
        .VPN_W(VPN_W), .L2_IDX_W(L2_IDX_W), .PA_W(PA_W),
        .OFF_W(OFF_W), .ENTRY_SH(ENTRY_SH)
    ) u_addr (
        .vpn(walk_q.vpn), .root(walk_q.root), .tbl_ppn(walk_q.tbl),
        .second(use_l2), .addr(mem_req_addr)
    );

    ptw_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W), .PERM_W(PERM_W)) u_dec (
        .entry(mem_rsp_data), .valid(dec_valid), .ppn(dec_ppn),
        .perm(dec_perm), .attr(dec_attr)
    );

    always_comb begin
        walk_d = walk_q;
        case (walk_q.st)
            PW_IDLE: begin
                if (miss_valid) begin
                    walk_d.st   = PW_L1_REQ;
                    walk_d.vpn  = miss_vpn;
                    walk_d.root = root_ptr;
                end
            end
            PW_L1_REQ: if (mem_req_ready) walk_d.st = PW_L1_WAIT;
            PW_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (dec_valid) begin
                        walk_d.tbl = dec_ppn;
                        walk_d.st  = PW_L2_REQ;
                    end else begin
                        walk_d.flvl = 1'b0;
                        walk_d.st   = PW_FAULT;
                    end
                end
            end
            PW_L2_REQ: if (mem_req_ready) walk_d.st = PW_L2_WAIT;
            PW_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (dec_valid) begin
                        walk_d.ppn  = dec_ppn;
                        walk_d.perm = dec_perm;
                        walk_d.attr = dec_attr;
                        walk_d.st   = PW_DONE;
                    end else begin
                        walk_d.flvl = 1'b1;
                        walk_d.st   = PW_FAULT;
                    end
                end
            end
            PW_DONE:  walk_d.st = PW_IDLE;
            PW_FAULT: walk_d.st = PW_IDLE;
            default:  walk_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q    <= '0;
            walk_q.st <= PW_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy          = (walk_q.st != PW_IDLE);
    assign mem_req_valid = (walk_q.st == PW_L1_REQ) || (walk_q.st == PW_L2_REQ);
    assign done          = (walk_q.st == PW_DONE);
    assign fault         = (walk_q.st == PW_FAULT);
    assign fault_lvl     = walk_q.flvl;
    assign res_ppn       = walk_q.ppn;
    assign res_perm      = walk_q.perm;
    assign res_attr      = walk_q.attr;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && miss_valid) |=> busy); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!fault && !busy)); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !fault) |=> busy); // R8
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rsp_valid)); // R7
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic [19:0] miss_vpn = '0;
    logic [31:0] root_ptr = '0;
    logic        busy, mem_req_valid, done, fault, fault_lvl;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [19:0] res_ppn;
    logic [2:0]  res_perm;
    logic [7:0]  res_attr;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .root_ptr(root_ptr), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_lvl(fault_lvl),
        .res_ppn(res_ppn), .res_perm(res_perm), .res_attr(res_attr)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // poke: 0 none, 1 miss during first wait, 2 miss in the end pulse cycle,
    //       3 stray response during a stalled first request
    task automatic run_walk(input logic [19:0] vpn, input logic [31:0] root,
                            input logic [31:0] l1e, input logic [31:0] l2e,
                            input int stall, input int lat, input int poke);
        logic [31:0] a1, a2;
        a1 = root + {20'd0, vpn[19:10], 2'b00};
        a2 = {l1e[31:12], 12'h000} + {20'd0, vpn[9:0], 2'b00};
        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn; root_ptr = root;
        @(negedge clk);
        miss_valid = 1'b0; miss_vpn = ~vpn; root_ptr = ~root;
        chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
        chk(mem_req_valid && mem_req_addr == a1, "R3 first read address", mem_req_addr, a1);
        for (int i = 0; i < stall; i++) begin
            if (poke == 3 && i == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0; end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(mem_req_valid && mem_req_addr == a1, "R3 R9 request held while stalled", mem_req_addr, a1);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(!mem_req_valid, "R10 no request while first read outstanding", 32'(mem_req_valid), 32'd0);
        if (poke == 1) begin
            miss_valid = 1'b1; miss_vpn = 20'hABCDE;
            @(negedge clk);
            miss_valid = 1'b0;
        end
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = l1e;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        if (!l1e[0]) begin
            chk(fault && !fault_lvl && !done, "R5 first-level fault", {fault, fault_lvl, done}, 32'b100);
            chk(!mem_req_valid, "R5 no second read after first-level fault", 32'(mem_req_valid), 32'd0);
        end else begin
            chk(mem_req_valid && mem_req_addr == a2, "R4 second read address", mem_req_addr, a2);
            for (int i = 0; i < stall; i++) @(negedge clk);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lat) @(negedge clk);
            chk(!done && !fault && busy, "R10 still waiting for second response", {busy, done, fault}, 32'b100);
            mem_rsp_valid = 1'b1; mem_rsp_data = l2e;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (!l2e[0]) begin
                chk(fault && fault_lvl && !done, "R6 second-level fault", {fault, fault_lvl, done}, 32'b110);
            end else begin
                chk(done && !fault, "R7 done pulse", {done, fault}, 32'b10);
                chk(res_ppn == l2e[31:12], "R7 ppn", 32'(res_ppn), 32'(l2e[31:12]));
                chk(res_perm == l2e[3:1] && res_attr == l2e[11:4], "R7 perm and attr",
                    {res_perm, res_attr}, {l2e[3:1], l2e[11:4]});
            end
        end
        if (poke == 2) begin miss_valid = 1'b1; miss_vpn = 20'h12345; end
        @(negedge clk);
        miss_valid = 1'b0;
        chk(!busy && !done && !fault, "R8 idle after single pulse", {busy, done, fault}, 32'b000);
        @(negedge clk);
        chk(!busy && !mem_req_valid, "R2 no walk from ignored miss", {busy, mem_req_valid}, 32'b00);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fault && !mem_req_valid, "R1 reset outputs",
            {busy, done, fault, mem_req_valid}, 32'b0000);
    endtask

    task automatic t_basic();     run_walk(20'h00401, 32'h0001_0000, 32'h0002_3001, 32'h0ABC_D5A7, 0, 0, 0); endtask
    task automatic t_slow();      run_walk(20'h3FF2A, 32'h0000_8000, 32'h0077_7001, 32'hFEDC_B00B, 3, 5, 0); endtask
    task automatic t_l1_fault();  run_walk(20'h80010, 32'h0004_0000, 32'h0011_1000, 32'h0, 1, 2, 0); endtask
    task automatic t_l2_fault();  run_walk(20'h00003, 32'h0004_0000, 32'h0055_5003, 32'h1234_5FFE, 0, 1, 0); endtask
    task automatic t_busy_miss(); run_walk(20'h12C34, 32'h0009_0000, 32'h00AA_A001, 32'h0000_1003, 0, 2, 1); endtask
    task automatic t_done_miss(); run_walk(20'h55555, 32'h000A_0000, 32'h00BB_B001, 32'h00C0_0F0F, 0, 0, 2); endtask
    task automatic t_fault_miss(); run_walk(20'h00001, 32'h000B_0000, 32'h0000_0000, 32'h0, 0, 0, 2); endtask
    task automatic t_stray_rsp(); run_walk(20'hFFFFF, 32'h0FFF_F004, 32'hFFFF_F001, 32'h8000_0003, 2, 0, 3); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_slow();
        t_l1_fault();
        t_l2_fault();
        t_busy_miss();
        t_done_miss();
        t_fault_miss();
        t_stray_rsp();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule